// File: doc/BRIEF.md
# Crystal Frequency Correction Register Unit

This block keeps the two signed correction terms that trim a real-time clock crystal: a fixed offset calibration, and a temperature term that software refreshes from time to time. Both terms sit behind one 16-bit register port. The port has separate low-byte and high-byte write strobes and a select line that picks which term is accessed. The block adds the two terms as signed values and clamps the sum to ±240 ppm. It passes the clamped result to the clock's pulse-correction logic only when a calibration-cycle boundary pulse arrives, so a cycle that is already running always keeps the correction it started with.

Each term is stored in sign-magnitude form. Bit 15 is the sign (1 means negative) and bits 7:0 hold the magnitude in ppm. Bits 14:8 are ignored on write and read back as zero. The temperature sign is handled in two steps. A write to the high byte alone only parks the sign bit. The parked sign is adopted when the low byte is written, either in the same cycle or in any later cycle. A read of the temperature register returns the unclamped signed sum of both terms. Any write to the offset register discards the temperature term.

Top module: `rtc_comp_regs`

## Requirements
- R1: While `rst` is high at a clock edge, the effective output, both stored terms and the parked sign all become zero, so both register reads return 0x0000.
- R2: With `sel`=0, a low-byte write loads the offset magnitude from `wdata[7:0]` and a high-byte write loads the offset sign from `wdata[15]`. A read with `sel`=0 returns {sign, 7'b0, magnitude}.
- R3: With `sel`=1, a write with both strobes high loads the temperature sign from `wdata[15]` and the magnitude from `wdata[7:0]` at the same clock edge.
- R4: With `sel`=1, a write with only the high-byte strobe parks `wdata[15]` and does not change the active temperature term, its read-back sum or the effective output.
- R5: With `sel`=1, a write with only the low-byte strobe loads the magnitude and makes the parked sign the active temperature sign.
- R6: Any offset write (`sel`=0, either strobe) sets the temperature term to +0 and clears the parked sign.
- R7: A read with `sel`=1 returns offset plus temperature term as a 16-bit two's-complement value, without clamping.
- R8: At a clock edge where `cyc_start` is high, `eff_ppm` takes the signed sum of the terms clamped to the range −240..+240, as a 10-bit two's-complement value. For example, +150 plus +200 gives +240.
- R9: When `run_en` is low at a boundary, the temperature term is left out and `eff_ppm` takes the clamped offset alone.
- R10: `eff_ppm` changes only at edges where `cyc_start` is high. Register writes between boundaries have no effect on it until the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Clock module running; gates the temperature term |
| cyc_start | input | 1 | One-cycle pulse at each calibration-cycle boundary |
| sel | input | 1 | Register select: 0 offset, 1 temperature |
| wr_lo | input | 1 | Low-byte write strobe |
| wr_hi | input | 1 | High-byte write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register |
| eff_ppm | output | 10 | Effective correction, two's complement, in ppm |

## Verification
The assertions assume that `cyc_start` is a clean, synchronous pulse and that the strobes and `wdata` are steady around each rising edge. They also assume that a high-byte-only temperature write is meant to leave the active term untouched until a low-byte write follows. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It never writes in a cycle that also carries a boundary pulse, so each check can be tied to a single cause. The stimulus covers magnitudes at both ends of the byte range and both signs, and it leads the sum into both clamps and to the exact limit.

// File: rtl/rtc_comp_pkg.sv
package rtc_comp_pkg;

    localparam int MAG_W  = 8;
    localparam int DATA_W = 16;
    localparam int SUM_W  = MAG_W + 2;
    localparam int EFF_W  = SUM_W;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
    } sm_t;

    typedef enum logic {
        SEL_OFS = 1'b0,
        SEL_TMP = 1'b1
    } sel_e;

    function automatic logic signed [SUM_W-1:0] sm_to_tc(input sm_t v);
        logic signed [SUM_W-1:0] m;
        m = $signed({2'b00, v.mag});
        return v.sign ? -m : m;
    endfunction

    function automatic logic signed [EFF_W-1:0] clamp(
        input logic signed [SUM_W-1:0] s,
        input int                      lim
    );
        logic signed [SUM_W-1:0] hi;
        logic signed [SUM_W-1:0] lo;
        hi = SUM_W'(lim);
        lo = -hi;
        if (s > hi)      return EFF_W'(hi);
        else if (s < lo) return EFF_W'(lo);
        else             return EFF_W'(s);
    endfunction

endpackage

// File: rtl/rtc_ofs_reg.sv
module rtc_ofs_reg
    import rtc_comp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output sm_t               ofs,
    output logic              ofs_wr
);
    sm_t ofs_q;

    assign ofs_wr = hit && (wr_lo || wr_hi);
    assign ofs    = ofs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q <= '0;
        end else if (hit) begin
            if (wr_lo) ofs_q.mag  <= wdata[MAG_W-1:0];
            if (wr_hi) ofs_q.sign <= wdata[DATA_W-1];
        end
    end
endmodule

// File: rtl/rtc_tcmp_reg.sv
module rtc_tcmp_reg
    import rtc_comp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              clr,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output sm_t               tcmp
);
    sm_t  tcmp_q;
    logic park_q;
    logic next_sign;

    // sign adopted on a low-byte write: fresh if the high byte comes along, parked otherwise
    assign next_sign = wr_hi ? wdata[DATA_W-1] : park_q;
    assign tcmp      = tcmp_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tcmp_q <= '0;
            park_q <= 1'b0;
        end else if (hit) begin
            if (wr_hi) park_q <= wdata[DATA_W-1];
            if (wr_lo) begin
                tcmp_q.mag  <= wdata[MAG_W-1:0];
                tcmp_q.sign <= next_sign;
            end
        end
    end
endmodule

// File: rtl/rtc_comp_sum.sv
module rtc_comp_sum
    import rtc_comp_pkg::*;
#(
    parameter int LIMIT_PPM = 240
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run_en,
    input  logic                    cyc_start,
    input  sm_t                     ofs,
    input  sm_t                     tcmp,
    output logic signed [SUM_W-1:0] raw_sum,
    output logic signed [EFF_W-1:0] eff
);
    logic signed [SUM_W-1:0] ofs_tc;
    logic signed [SUM_W-1:0] tmp_tc;
    logic signed [SUM_W-1:0] applied;
    logic                    tmp_live;
    logic signed [EFF_W-1:0] eff_q;

    assign ofs_tc   = sm_to_tc(ofs);
    assign tmp_tc   = sm_to_tc(tcmp);
    assign raw_sum  = ofs_tc + tmp_tc;
    assign tmp_live = run_en && (tcmp.mag != '0);
    assign applied  = tmp_live ? raw_sum : ofs_tc;
    assign eff      = eff_q;

    always_ff @(posedge clk) begin
        if (rst)            eff_q <= '0;
        else if (cyc_start) eff_q <= clamp(applied, LIMIT_PPM);
    end
endmodule

// File: rtl/rtc_comp_regs.sv
module rtc_comp_regs
    import rtc_comp_pkg::*;
#(
    parameter int LIMIT_PPM = 240
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              cyc_start,
    input  logic              sel,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [EFF_W-1:0]  eff_ppm
);
    sm_t                     ofs;
    sm_t                     tcmp;
    logic                    ofs_wr;
    logic signed [SUM_W-1:0] raw_sum;
    logic signed [EFF_W-1:0] eff;
    logic                    hit_ofs;
    logic                    hit_tmp;

    assign hit_ofs = (sel_e'(sel) == SEL_OFS);
    assign hit_tmp = (sel_e'(sel) == SEL_TMP);

    rtc_ofs_reg u_ofs (
        .clk(clk), .rst(rst), .hit(hit_ofs), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wdata(wdata), .ofs(ofs), .ofs_wr(ofs_wr)
    );

    rtc_tcmp_reg u_tcmp (
        .clk(clk), .rst(rst), .hit(hit_tmp), .clr(ofs_wr), .wr_lo(wr_lo),
        .wr_hi(wr_hi), .wdata(wdata), .tcmp(tcmp)
    );

    rtc_comp_sum #(.LIMIT_PPM(LIMIT_PPM)) u_sum (
        .clk(clk), .rst(rst), .run_en(run_en), .cyc_start(cyc_start),
        .ofs(ofs), .tcmp(tcmp), .raw_sum(raw_sum), .eff(eff)
    );

    always_comb begin
        if (hit_ofs) rdata = {ofs.sign, {(DATA_W-MAG_W-1){1'b0}}, ofs.mag};
        else         rdata = DATA_W'(raw_sum);
    end

    assign eff_ppm = eff;
endmodule

// File: rtl/rtc_comp_chk.sv
module rtc_comp_chk
    import rtc_comp_pkg::*;
#(
    parameter int LIMIT_PPM = 240
) (
    input logic             clk,
    input logic             rst,
    input logic             cyc_start,
    input logic             sel,
    input logic             wr_lo,
    input logic             wr_hi,
    input logic [EFF_W-1:0] eff_ppm,
    input sm_t              tcmp
);
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (eff_ppm == '0));

    assert_within_limit_R8: assert property (@(posedge clk) disable iff (rst)
        ($signed(eff_ppm) <= LIMIT_PPM) && ($signed(eff_ppm) >= -LIMIT_PPM));

    assert_hold_between_R10: assert property (@(posedge clk) disable iff (rst)
        !cyc_start |=> $stable(eff_ppm));

    assert_ofs_clears_tmp_R6: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_OFS && (wr_lo || wr_hi)) |=> (tcmp == '0));

    assert_sign_parked_R4: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_TMP && wr_hi && !wr_lo) |=> $stable(tcmp));
endmodule

bind rtc_comp_regs rtc_comp_chk #(.LIMIT_PPM(LIMIT_PPM)) u_chk (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .sel(sel), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .eff_ppm(eff_ppm), .tcmp(tcmp)
);

// File: tb/test_rtc_comp_regs.sv
module test_rtc_comp_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b1;
    logic        cyc_start = 1'b0;
    logic        sel = 1'b0;
    logic        wr_lo = 1'b0;
    logic        wr_hi = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [9:0]  eff_ppm;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rtc_comp_regs i_rtc_comp_regs (
        .clk(clk), .rst(rst), .run_en(run_en), .cyc_start(cyc_start), .sel(sel),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wdata), .rdata(rdata), .eff_ppm(eff_ppm)
    );

    // offset word, temperature word, run_en, expected effective, expected sum
    localparam int NV = 8;
    localparam logic [15:0] V_OFS [NV] = '{16'h0096, 16'h8096, 16'h0064, 16'h8014,
                                          16'h0064, 16'h00FF, 16'h00C8, 16'h8010};
    localparam logic [15:0] V_TMP [NV] = '{16'h00C8, 16'h80C8, 16'h801E, 16'h0032,
                                          16'h0032, 16'h0000, 16'h0028, 16'h0010};
    localparam bit          V_RUN [NV] = '{1, 1, 1, 1, 0, 1, 1, 1};
    localparam int          V_EFF [NV] = '{240, -240, 70, 30, 100, 240, 240, 0};
    localparam int          V_SUM [NV] = '{350, -350, 70, 30, 150, 255, 240, 0};

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit s, input bit lo, input bit hi, input logic [15:0] d);
        @(negedge clk);
        sel = s; wr_lo = lo; wr_hi = hi; wdata = d;
        @(negedge clk);
        wr_lo = 1'b0; wr_hi = 1'b0;
    endtask

    task automatic boundary();
        @(negedge clk);
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    function automatic int eff_i();
        return int'($signed(eff_ppm));
    endfunction

    function automatic int rd_i();
        return int'($signed(rdata));
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 eff", eff_i(), 0);
        sel = 1'b0; #1; check("R1 ofs read", int'(rdata), 0);
        sel = 1'b1; #1; check("R1 tmp read", int'(rdata), 0);

        // table walk: R3 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            run_en = V_RUN[i];
            wr(1'b0, 1'b1, 1'b1, V_OFS[i]);
            wr(1'b1, 1'b1, 1'b1, V_TMP[i]);
            sel = 1'b1; #1;
            check($sformatf("R7 sum vec%0d", i), rd_i(), V_SUM[i]);
            boundary();
            check($sformatf("R8 R9 eff vec%0d", i), eff_i(), V_EFF[i]);
        end
        run_en = 1'b1;

        // R2: offset read format, separate bytes
        wr(1'b0, 1'b1, 1'b0, 16'h00AB);
        wr(1'b0, 1'b0, 1'b1, 16'h8000);
        sel = 1'b0; #1;
        check("R2 ofs read", int'(rdata), 16'h80AB);

        // setup +10 / +20
        wr(1'b0, 1'b1, 1'b1, 16'h000A);
        wr(1'b1, 1'b1, 1'b1, 16'h0014);
        boundary();
        check("R3 eff", eff_i(), 30);

        // R4: high-byte-only write parks the sign
        wr(1'b1, 1'b0, 1'b1, 16'h8000);
        sel = 1'b1; #1;
        check("R4 sum unchanged", rd_i(), 30);
        boundary();
        check("R4 eff unchanged", eff_i(), 30);

        // R5: low-byte write adopts the parked sign
        wr(1'b1, 1'b1, 1'b0, 16'h0014);
        sel = 1'b1; #1;
        check("R5 sum", rd_i(), -10);
        // R10: no boundary yet
        @(negedge clk);
        check("R10 eff held", eff_i(), 30);
        boundary();
        check("R5 eff", eff_i(), -10);

        // R6: offset high-byte-only write clears the temperature term
        wr(1'b0, 1'b0, 1'b1, 16'h0000);
        sel = 1'b1; #1;
        check("R6 sum", rd_i(), 10);
        // parked sign was cleared too: low-only temperature write is positive
        wr(1'b1, 1'b1, 1'b0, 16'h0005);
        sel = 1'b1; #1;
        check("R6 parked cleared", rd_i(), 15);
        check("R10 eff held", eff_i(), -10);
        boundary();
        check("R8 eff", eff_i(), 15);

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 eff after reset", eff_i(), 0);
        sel = 1'b1; #1;
        check("R1 sum after reset", rd_i(), 0);

        finish_run();
    end
endmodule